// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block keeps a table of buffer descriptors in local registers and walks the transmit part of that table in ring order. Each descriptor is two 32-bit words: a control/status word and a buffer address word. When software hands a descriptor over by setting its ready bit, the sequencer offers the buffer address, the frame length and the per-frame pad and CRC options to a transmitter through a start strobe. It then waits for the transmitter's done pulse and its result bits. It writes that result back into the same descriptor, returns ownership to software, and raises an event in an interrupt source register.

Software reaches the block through a simple 32-bit register port with a word address. The mode register sits at word 0, the interrupt source register at word 1, the interrupt mask at word 2 and the transmit-count register at word 3. The descriptor table starts at word 0x100, which is byte offset 0x400. Transmit and receive descriptors share the table. The transmit-count register sets where the transmit part ends. The receive side is not built here, but its five event lines feed the shared interrupt source register.

Top module: `txring_seq`

## Requirements
- R1: After reset the mode, source, mask and count registers read 0, every descriptor word reads 0, `irq` is low and `tx_start` is low.
- R2: Writing a value above NUM_DESC to the count register (word 3) stores NUM_DESC, and a smaller value is stored as written. While the count is 0 the sequencer never starts a frame.
- R3: Descriptor e occupies word 0x100+2e (control/status) and word 0x100+2e+1 (buffer address). Both words can be written and read back.
- R4: With mode bit 0 (transmit enable) set and a nonzero count, a descriptor whose control bit 15 (ready) is set produces a one-cycle `tx_start`. With it come `tx_addr` equal to the address word, `tx_len` equal to bits 31:16, `tx_pad` equal to bit 12 and `tx_crc` equal to bit 11. A descriptor with bit 15 clear never starts.
- R5: `tx_addr`, `tx_len`, `tx_pad` and `tx_crc` hold steady from the start strobe until `tx_done`. A `tx_done` pulse that arrives while no frame is in flight changes no descriptor and no source bit.
- R6: On `tx_done`, the descriptor's control word takes `tx_result` in bits 8:0 and has bit 15 cleared. Bits 31:16 and 14:9 keep their values.
- R7: After a descriptor with bit 13 (wrap) set, the next descriptor polled is entry 0. Otherwise it is the next entry.
- R8: On `tx_done` for a descriptor with bit 14 set, source bit 1 is set if `tx_result` has any of bits 0, 2, 3 or 8 set, and source bit 0 is set otherwise. With bit 14 clear, no source bit is set.
- R9: Source bits latch whatever the mask holds. `rx_evt[k]` sets source bit k+2. Writing 1 to a source bit clears it, writing 0 leaves it alone, and a set arriving in the same cycle as a clear wins.
- R10: `irq` is high exactly when some source bit and the same mask bit (word 2) are both 1.
- R11: Clearing mode bit 0 while a frame is in flight lets that frame complete and write back. No further frame starts until the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe; data appears on `host_rdata` the next cycle |
| host_addr | input | 10 | Word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| rx_evt | input | 5 | Receive-side event pulses, feeding source bits 6:2 |
| irq | output | 1 | Interrupt request |
| tx_start | output | 1 | One-cycle frame start strobe |
| tx_addr | output | 32 | Buffer address of the frame in flight |
| tx_len | output | 16 | Frame length in bytes |
| tx_pad | output | 1 | Pad frames shorter than 64 bytes up to 64 |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | One-cycle frame completion pulse |
| tx_result | input | 9 | Completion result bits, valid with `tx_done` |

## Verification
The assertions assume that the transmitter sends `tx_done` only after it has seen a start. They also assume that software leaves a descriptor alone between setting its ready bit and the write-back. The bench keeps to both: it arms one descriptor at a time, and it drives done only after it has observed the start strobe and checked the offered fields. The one exception is a single deliberate stray done, sent while the sequencer is idle, which tests that such a pulse is ignored.

// File: rtl/tdrs_pkg.sv
package tdrs_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned RES_W     = 9;
   localparam int unsigned LEN_W     = 16;
   localparam int unsigned LEN_LSB   = 16;
   localparam int unsigned B_RDY     = 15;
   localparam int unsigned B_IE      = 14;
   localparam int unsigned B_WRAP    = 13;
   localparam int unsigned B_PAD     = 12;
   localparam int unsigned B_CRC     = 11;
   localparam int unsigned EV_W      = 7;
   localparam int unsigned EV_TXF    = 0;
   localparam int unsigned EV_TXE    = 1;
   localparam int unsigned RXEV_W    = 5;
   // result bits that count as a failed frame: carrier, late coll, retry limit, underrun
   localparam logic [RES_W-1:0]  ERR_BITS = 9'h10D;
   // control bits cleared on write-back: ready and the old result field
   localparam logic [WORD_W-1:0] WB_CLEAR = 32'h0000_81FF;

   typedef enum logic {SEQ_POLL = 1'b0, SEQ_BUSY = 1'b1} seq_state_t;
   typedef enum logic [1:0] {RS_MODE = 2'd0, RS_SRC = 2'd1,
                             RS_MASK = 2'd2, RS_CNT = 2'd3} reg_sel_t;
endpackage

// File: rtl/tdrs_desc_table.sv
module tdrs_desc_table
   import tdrs_pkg::*;
#(
   parameter int unsigned NUM_DESC = 128,
   parameter int unsigned IDX_W    = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_we,
   input  logic [IDX_W-1:0]  h_idx,
   input  logic              h_hi,
   input  logic [WORD_W-1:0] h_wdata,
   input  logic [IDX_W-1:0]  h_ridx,
   input  logic              h_rhi,
   output logic [WORD_W-1:0] h_rdata,
   input  logic [IDX_W-1:0]  s_idx,
   output logic [WORD_W-1:0] s_ctrl,
   output logic [WORD_W-1:0] s_addr,
   input  logic              s_we,
   input  logic [WORD_W-1:0] s_wdata
);
   logic [WORD_W-1:0] ctrl_arr [NUM_DESC];
   logic [WORD_W-1:0] addr_arr [NUM_DESC];

   for (genvar e = 0; e < NUM_DESC; e++) begin : g_ent
      logic [WORD_W-1:0] ctrl_r, addr_r;
      logic hit_s, hit_h;
      assign hit_s = s_we && (s_idx == IDX_W'(e));
      assign hit_h = h_we && (h_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctrl_r <= '0;
            addr_r <= '0;
         end else begin
            // sequencer write-back wins over a host write to the same word
            if (hit_s)
               ctrl_r <= s_wdata;
            else if (hit_h && !h_hi)
               ctrl_r <= h_wdata;
            if (hit_h && h_hi)
               addr_r <= h_wdata;
         end
      end
      assign ctrl_arr[e] = ctrl_r;
      assign addr_arr[e] = addr_r;
   end

   assign h_rdata = h_rhi ? addr_arr[h_ridx] : ctrl_arr[h_ridx];
   assign s_ctrl  = ctrl_arr[s_idx];
   assign s_addr  = addr_arr[s_idx];

   p_wb_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s_we |=> ctrl_arr[$past(s_idx)] == $past(s_wdata));
endmodule

// File: rtl/tdrs_regs.sv
module tdrs_regs
   import tdrs_pkg::*;
#(
   parameter int unsigned NUM_DESC = 128,
   parameter int unsigned CNT_W    = $clog2(NUM_DESC) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_we,
   input  reg_sel_t          h_sel,
   input  logic [WORD_W-1:0] h_wdata,
   input  reg_sel_t          h_rsel,
   output logic [WORD_W-1:0] rdata,
   input  logic [EV_W-1:0]   ev_set,
   output logic              tx_en,
   output logic [CNT_W-1:0]  tx_cnt,
   output logic              irq
);
   logic [EV_W-1:0]  src_q, mask_q, clr;
   logic [CNT_W-1:0] cnt_d;

   assign clr   = (h_we && h_sel == RS_SRC) ? h_wdata[EV_W-1:0] : '0;
   assign cnt_d = (h_wdata > WORD_W'(NUM_DESC)) ? CNT_W'(NUM_DESC)
                                                 : h_wdata[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en  <= 1'b0;
         src_q  <= '0;
         mask_q <= '0;
         tx_cnt <= '0;
      end else begin
         src_q <= (src_q & ~clr) | ev_set;
         if (h_we) begin
            case (h_sel)
               RS_MODE: tx_en  <= h_wdata[0];
               RS_MASK: mask_q <= h_wdata[EV_W-1:0];
               RS_CNT:  tx_cnt <= cnt_d;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (h_rsel)
         RS_MODE: rdata = {{(WORD_W-1){1'b0}}, tx_en};
         RS_SRC:  rdata = {{(WORD_W-EV_W){1'b0}}, src_q};
         RS_MASK: rdata = {{(WORD_W-EV_W){1'b0}}, mask_q};
         default: rdata = {{(WORD_W-CNT_W){1'b0}}, tx_cnt};
      endcase
   end

   assign irq = |(src_q & mask_q);

   p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_we && h_sel == RS_SRC) |=> (src_q & $past(src_q)) == $past(src_q));
   p_cnt_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CNT_W'(NUM_DESC));
endmodule

// File: rtl/tdrs_walker.sv
module tdrs_walker
   import tdrs_pkg::*;
#(
   parameter int unsigned IDX_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              cnt_nz,
   output logic [IDX_W-1:0]  s_idx,
   input  logic [WORD_W-1:0] s_ctrl,
   input  logic [WORD_W-1:0] s_addr,
   output logic              s_we,
   output logic [WORD_W-1:0] s_wdata,
   output logic              tx_start,
   output logic [WORD_W-1:0] tx_addr,
   output logic [LEN_W-1:0]  tx_len,
   output logic              tx_pad,
   output logic              tx_crc,
   input  logic              tx_done,
   input  logic [RES_W-1:0]  tx_result,
   output logic              ev_txf,
   output logic              ev_txe
);
   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             ie_q, wrap_q, finish, failed;

   assign s_idx   = idx_q;
   assign finish  = (state_q == SEQ_BUSY) && tx_done;
   assign failed  = |(tx_result & ERR_BITS);
   assign s_we    = finish;
   assign s_wdata = (s_ctrl & ~WB_CLEAR) | {{(WORD_W-RES_W){1'b0}}, tx_result};
   assign ev_txf  = finish && ie_q && !failed;
   assign ev_txe  = finish && ie_q && failed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SEQ_POLL;
         idx_q    <= '0;
         ie_q     <= 1'b0;
         wrap_q   <= 1'b0;
         tx_start <= 1'b0;
         tx_addr  <= '0;
         tx_len   <= '0;
         tx_pad   <= 1'b0;
         tx_crc   <= 1'b0;
      end else begin
         tx_start <= 1'b0;
         case (state_q)
            SEQ_POLL: begin
               if (tx_en && cnt_nz && s_ctrl[B_RDY]) begin
                  state_q  <= SEQ_BUSY;
                  tx_start <= 1'b1;
                  tx_addr  <= s_addr;
                  tx_len   <= s_ctrl[LEN_LSB +: LEN_W];
                  tx_pad   <= s_ctrl[B_PAD];
                  tx_crc   <= s_ctrl[B_CRC];
                  ie_q     <= s_ctrl[B_IE];
                  wrap_q   <= s_ctrl[B_WRAP];
               end
            end
            default: begin
               if (tx_done) begin
                  state_q <= SEQ_POLL;
                  idx_q   <= wrap_q ? '0 : idx_q + 1'b1;
               end
            end
         endcase
      end
   end

   p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
   p_hold_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_BUSY && !tx_done) |=> ($stable(tx_addr) && $stable(tx_len)
                                            && $stable(tx_pad) && $stable(tx_crc)));
   p_back_to_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> state_q == SEQ_POLL);
   p_start_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(tx_en));
endmodule

// File: rtl/txring_seq.sv
module txring_seq
   import tdrs_pkg::*;
#(
   parameter int unsigned NUM_DESC = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic                 host_re,
   input  logic [9:0]           host_addr,
   input  logic [WORD_W-1:0]    host_wdata,
   output logic [WORD_W-1:0]    host_rdata,
   input  logic [RXEV_W-1:0]    rx_evt,
   output logic                 irq,
   output logic                 tx_start,
   output logic [WORD_W-1:0]    tx_addr,
   output logic [LEN_W-1:0]     tx_len,
   output logic                 tx_pad,
   output logic                 tx_crc,
   input  logic                 tx_done,
   input  logic [RES_W-1:0]     tx_result
);
   localparam int unsigned IDX_W = $clog2(NUM_DESC);
   localparam int unsigned CNT_W = IDX_W + 1;

   initial begin
      if (NUM_DESC < 2 || NUM_DESC > 128)
         $error("NUM_DESC must lie in 2..128");
      if ((NUM_DESC & (NUM_DESC - 1)) != 0)
         $error("NUM_DESC must be a power of two");
   end

   logic              in_tab, in_reg, tab_ok, h_tab_we, h_reg_we;
   logic [6:0]        ent;
   logic [IDX_W-1:0]  h_idx, s_idx;
   logic [WORD_W-1:0] t_rdata, r_rdata, s_ctrl, s_addr, s_wdata;
   logic              s_we, tx_en, ev_txf, ev_txe;
   logic [CNT_W-1:0]  tx_cnt;
   logic [EV_W-1:0]   ev_set;
   reg_sel_t          sel;

   assign in_tab   = host_addr[9:8] == 2'b01;
   assign in_reg   = (host_addr[9:8] == 2'b00) && (host_addr[7:2] == 6'd0);
   assign ent      = host_addr[7:1];
   assign tab_ok   = in_tab && (32'(ent) < NUM_DESC);
   assign h_idx    = ent[IDX_W-1:0];
   assign sel      = reg_sel_t'(host_addr[1:0]);
   assign h_tab_we = host_we && tab_ok;
   assign h_reg_we = host_we && in_reg;
   assign ev_set   = {rx_evt, ev_txe, ev_txf};

   tdrs_desc_table #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .h_we(h_tab_we), .h_idx(h_idx), .h_hi(host_addr[0]), .h_wdata(host_wdata),
      .h_ridx(h_idx), .h_rhi(host_addr[0]), .h_rdata(t_rdata),
      .s_idx(s_idx), .s_ctrl(s_ctrl), .s_addr(s_addr),
      .s_we(s_we), .s_wdata(s_wdata));

   tdrs_regs #(.NUM_DESC(NUM_DESC), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .h_we(h_reg_we), .h_sel(sel), .h_wdata(host_wdata),
      .h_rsel(sel), .rdata(r_rdata), .ev_set(ev_set),
      .tx_en(tx_en), .tx_cnt(tx_cnt), .irq(irq));

   tdrs_walker #(.IDX_W(IDX_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .tx_en(tx_en), .cnt_nz(|tx_cnt),
      .s_idx(s_idx), .s_ctrl(s_ctrl), .s_addr(s_addr),
      .s_we(s_we), .s_wdata(s_wdata),
      .tx_start(tx_start), .tx_addr(tx_addr), .tx_len(tx_len),
      .tx_pad(tx_pad), .tx_crc(tx_crc),
      .tx_done(tx_done), .tx_result(tx_result),
      .ev_txf(ev_txf), .ev_txe(ev_txe));

   always_ff @(posedge clk) begin
      if (!rst_n)
         host_rdata <= '0;
      else if (host_re)
         host_rdata <= tab_ok ? t_rdata : (in_reg ? r_rdata : '0);
   end

   p_cnt_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(tx_cnt) != '0);
endmodule

// File: tb/txring_seq_test.sv
module txring_seq_test;
   localparam int unsigned ND = 8;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        host_we = 0, host_re = 0;
   logic [9:0]  host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic [4:0]  rx_evt = '0;
   logic        irq, tx_start, tx_pad, tx_crc;
   logic [31:0] tx_addr;
   logic [15:0] tx_len;
   logic        tx_done = 0;
   logic [8:0]  tx_result = '0;

   int total = 0, bad = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   txring_seq #(.NUM_DESC(ND)) uut (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
      @(negedge clk); host_we = 0;
   endtask

   task automatic hread(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk); host_re = 1; host_addr = a;
      @(negedge clk); host_re = 0; d = host_rdata;
   endtask

   task automatic expect_reg(input logic [9:0] a, input logic [31:0] e, input string req);
      logic [31:0] d;
      hread(a, d);
      check(d === e, req, d, e);
   endtask

   task automatic wait_start(output bit got);
      got = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (tx_start) begin got = 1; return; end
      end
   endtask

   task automatic no_start(input int n, input string req);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tx_start) seen = 1;
      end
      check(!seen, req, 32'(seen), 0);
   endtask

   task automatic pulse_done(input logic [8:0] r);
      @(negedge clk); tx_done = 1; tx_result = r;
      @(negedge clk); tx_done = 0; tx_result = '0;
   endtask

   function automatic logic [9:0] cw(input int e); return 10'(32'h100 + 2*e); endfunction
   function automatic logic [9:0] aw(input int e); return 10'(32'h100 + 2*e + 1); endfunction

   // arm descriptor, see start, check fields, hold, complete, check write-back and event
   task automatic frame(input int p, input int k, input bit ie, input bit wrap,
                        input logic [8:0] res, input bit mid_disable);
      logic [31:0] ctrl, addr, d, expev;
      bit got, steady;
      logic [15:0] len;
      len  = 16'(40 + k*7);
      addr = 32'h1000_0000 + 32'(k*256 + p);
      ctrl = {len, 1'b1, ie, wrap, k[0], k[1], 2'b01, 9'h0AA};
      hwrite(aw(p), addr);
      hwrite(cw(p), ctrl);
      wait_start(got);
      check(got, "R4 start seen", 32'(got), 1);
      check(tx_addr === addr, "R4 tx_addr", tx_addr, addr);
      check(tx_len === len, "R4 tx_len", 32'(tx_len), 32'(len));
      check({tx_pad, tx_crc} === {k[0], k[1]}, "R4 pad/crc", 32'({tx_pad, tx_crc}), 32'({k[0], k[1]}));
      if (mid_disable) hwrite(10'h000, 0);
      steady = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (tx_start || tx_addr !== addr || tx_len !== len) steady = 0;
      end
      check(steady, "R5 fields held", 32'(steady), 1);
      pulse_done(res);
      hread(cw(p), d);
      check(d === ((ctrl & ~32'h81FF) | 32'(res)), "R6 write-back", d, (ctrl & ~32'h81FF) | 32'(res));
      expev = !ie ? 0 : ((res & 9'h10D) != 0 ? 32'h2 : 32'h1);
      hread(10'h001, d);
      check(d === expev, "R8 event", d, expev);
      hwrite(10'h001, 32'h3);
   endtask

   initial begin
      logic [31:0] d;
      int ptr;
      bit got;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check(irq === 0 && tx_start === 0, "R1 outputs", 32'({irq, tx_start}), 0);
      for (int a = 0; a < 4; a++) expect_reg(10'(a), 0, "R1 register");
      for (int e = 0; e < ND; e++) begin
         expect_reg(cw(e), 0, "R1 ctrl word");
         expect_reg(aw(e), 0, "R1 addr word");
      end
      // R3 table read/write
      hwrite(aw(ND-1), 32'hCAFE_0001);
      hwrite(cw(ND-1), 32'h0000_1234);
      expect_reg(aw(ND-1), 32'hCAFE_0001, "R3 addr word");
      expect_reg(cw(ND-1), 32'h0000_1234, "R3 ctrl word");
      hwrite(cw(ND-1), 0);
      // R2 clamp
      hwrite(10'h003, 32'd200);
      expect_reg(10'h003, ND, "R2 clamp high");
      hwrite(10'h003, 32'd5);
      expect_reg(10'h003, 5, "R2 value kept");
      // R2 zero count blocks start
      hwrite(10'h003, 0);
      hwrite(10'h000, 1);
      hwrite(aw(0), 32'h2000_0000);
      hwrite(cw(0), 32'h0040_8000);
      no_start(20, "R2 count zero");
      hwrite(10'h003, ND);
      wait_start(got);
      check(got, "R2 start after count set", 32'(got), 1);
      pulse_done(9'h000);
      hwrite(10'h001, 32'h3);
      ptr = 1;
      // R4 not ready: descriptor without bit 15
      hwrite(cw(ptr), 32'h0040_4000);
      no_start(15, "R4 not ready");
      // sweep: many results, IE on/off, wrap at entry 5 (R6 R7 R8)
      for (int k = 0; k < 20; k++) begin
         bit wr, ie;
         logic [8:0] res;
         wr  = (ptr == 5);
         ie  = (k % 5 != 4);
         res = (k < 9) ? 9'(1 << k) : 9'((k * 37) & 9'h1FF);
         frame(ptr, k, ie, wr, res, 0);
         ptr = wr ? 0 : ptr + 1;
      end
      // R7 natural rollover past the last entry without wrap
      while (ptr != 0) begin
         frame(ptr, 3, 1, 0, 9'h000, 0);
         ptr = (ptr + 1) % ND;
      end
      check(1, "R7 rollover reached entry 0", 0, 0);
      // R5 stray done while idle changes nothing
      hread(cw(ND-1), d);
      pulse_done(9'h1FF);
      expect_reg(cw(ND-1), d, "R5 stray done descriptor");
      expect_reg(10'h001, 0, "R5 stray done source");
      // R11 disable mid-frame
      frame(ptr, 6, 1, 0, 9'h010, 1);
      ptr = ptr + 1;
      hwrite(aw(ptr), 32'h3000_0000);
      hwrite(cw(ptr), 32'h0050_8000);
      no_start(20, "R11 stopped");
      hwrite(10'h000, 1);
      wait_start(got);
      check(got, "R11 restart", 32'(got), 1);
      check(tx_addr === 32'h3000_0000, "R11 next descriptor", tx_addr, 32'h3000_0000);
      pulse_done(9'h000);
      hwrite(10'h001, 32'h3);
      // R9 / R10 latching, masking, clearing
      hwrite(10'h002, 0);
      @(negedge clk); rx_evt = 5'b10101;
      @(negedge clk); rx_evt = 0;
      expect_reg(10'h001, 32'h54, "R9 latch while masked");
      check(irq === 0, "R10 irq masked", 32'(irq), 0);
      hwrite(10'h002, 32'h04);
      check(irq === 1, "R10 irq on mask", 32'(irq), 1);
      hwrite(10'h001, 32'h04);
      expect_reg(10'h001, 32'h50, "R9 write-1 clear");
      check(irq === 0, "R10 irq after clear", 32'(irq), 0);
      @(negedge clk); host_we = 1; host_addr = 10'h001; host_wdata = 32'h10; rx_evt = 5'b00100;
      @(negedge clk); host_we = 0; rx_evt = 0;
      expect_reg(10'h001, 32'h50, "R9 set beats clear");
      hwrite(10'h001, 32'h7F);
      expect_reg(10'h001, 0, "R9 all cleared");
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule